// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers six interrupt requests: two external lines, a speech-end event, two timer overflows and a time-base tick. Each request is held in its own pending latch. Hardware can set a latch; software can only clear one. The latches pass through a global enable and a small group-enable register. A fixed-priority selector then picks the winning source and presents a registered interrupt request together with that source's entry address.

The CPU side takes the request with a single-cycle acknowledge. The acknowledge clears the winning latch and drops the global enable. Software must set the global enable again before another interrupt can be taken, which is how nesting is allowed. Sources are numbered by index 0 to 5, and index 0 has the highest priority. The sources are: 0 external line A, 1 speech-end, 2 timer A overflow, 3 timer B overflow, 4 time base, 5 external line B.

Top module: `vintc_top`

## Requirements
- R1: After a synchronous reset, `pend_o`, `irq_o` and `ei_o` are all zero, and all four group-enable bits are zero.
- R2: A one-cycle pulse on `src_req[i]` sets `pend_o[i]` at the next clock edge. The latch holds that value until it is cleared, whatever the global enable and group enables are.
- R3: When `clr_wr`=1, each latch whose `clr_mask` bit is 1 is cleared at the next edge. Latches whose mask bit is 0 are left unchanged. No software input can set a latch.
- R4: If `src_req[i]` and a clear of latch i arrive in the same cycle, the latch ends up set.
- R5: Source 0 is gated only by the global enable. It raises `irq_o` with the group-enable register at zero once `ei_o`=1, and it never raises `irq_o` while `ei_o`=0.
- R6: Sources 1 to 5 each need `ei_o`=1 and their group-enable bit. Bit 3 serves source 1. Bit 2 serves source 2. Bit 1 is shared by sources 3 and 4. Bit 0 serves source 5.
- R7: Among the latches that are pending and enabled, the lowest index wins. `vec_o` is then 2 + 2×index, which gives 0x02, 0x04, 0x06, 0x08, 0x0A and 0x0C.
- R8: `ack`=1 while `irq_o`=1 clears the winning latch and clears `ei_o` at the next edge. On that same edge `irq_o` falls to 0. If `ei_set` is asserted in that cycle, it takes priority over the clear of `ei_o`.
- R9: `ack` while `irq_o`=0 has no effect on the latches or on `ei_o`.
- R10: `irq_o` and `vec_o` are registered. They reflect the latch state one edge after the latch changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 6 | Request pulses, index 0 = highest priority |
| clr_wr | input | 1 | Strobe for the write-one-to-clear of the latches |
| clr_mask | input | 6 | Latches to clear when `clr_wr`=1 |
| ei_set | input | 1 | Set the global enable |
| ei_clr | input | 1 | Clear the global enable |
| mask_wr | input | 1 | Write strobe for the group-enable register |
| mask_data | input | 4 | New group-enable value |
| ack | input | 1 | Interrupt acknowledge |
| irq_o | output | 1 | Registered interrupt request |
| vec_o | output | 8 | Entry address of the winning source |
| pend_o | output | 6 | Current pending latches |
| ei_o | output | 1 | Current global enable |

## Verification
On every cycle, the assertions check the following:
- a request pulse always leaves its latch set;
- no latch ever rises without a request;
- `irq_o` appears only after a cycle in which the global enable was on;
- an acknowledge drops `irq_o` and the global enable;
- `vec_o` always holds one of the six legal entry addresses.

Some behaviours can only be shown by the bench's scenarios, because they depend on the exact vector value for a given pending set:
- the mask-bit-to-source mapping, including the shared bit;
- the priority order walked down through successive acknowledges;
- the set-over-clear collision;
- the absence of any effect from a stray acknowledge.

// File: rtl/vintc_pkg.sv
package vintc_pkg;
  localparam int NSRC  = 6;
  localparam int NGRP  = 4;
  localparam int VEC_W = 8;

  // group-enable bit serving each source; -1 means global enable only
  function automatic int grp_of(input int src);
    case (src)
      1:       return 3;
      2:       return 2;
      3:       return 1;
      4:       return 1;
      5:       return 0;
      default: return -1;
    endcase
  endfunction
endpackage

// File: rtl/intc_latch_bank.sv
module intc_latch_bank #(
  parameter int N = vintc_pkg::NSRC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_q
);
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_i) | set_i;
  end

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i))); // R4
  AST_NO_SOFT_SET: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(set_i)) == '0)); // R3
endmodule

// File: rtl/intc_prio_sel.sv
module intc_prio_sel #(
  parameter int N     = vintc_pkg::NSRC,
  parameter int NG    = vintc_pkg::NGRP,
  parameter int VEC_W = vintc_pkg::VEC_W,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     pend_i,
  input  logic             ei_i,
  input  logic [NG-1:0]    grp_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [N-1:0] gated;

  for (genvar g = 0; g < N; g++) begin : g_gate
    localparam int GI = vintc_pkg::grp_of(g);
    if (GI < 0) begin : g_ei_only
      assign gated[g] = pend_i[g] & ei_i;
    end else begin : g_masked
      assign gated[g] = pend_i[g] & ei_i & grp_i[GI];
    end
  end

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (gated[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
    vec_o = VEC_W'({idx_o, 1'b0}) + VEC_W'(2);
  end
endmodule

// File: rtl/vintc_top.sv
module vintc_top #(
  parameter int N     = vintc_pkg::NSRC,
  parameter int NG    = vintc_pkg::NGRP,
  parameter int VEC_W = vintc_pkg::VEC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     src_req,
  input  logic             clr_wr,
  input  logic [N-1:0]     clr_mask,
  input  logic             ei_set,
  input  logic             ei_clr,
  input  logic             mask_wr,
  input  logic [NG-1:0]    mask_data,
  input  logic             ack,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [N-1:0]     pend_o,
  output logic             ei_o
);
  localparam int IDX_W = $clog2(N);

  logic             ei_q;
  logic [NG-1:0]    grp_q;
  logic             irq_q;
  logic [VEC_W-1:0] vec_q;
  logic [IDX_W-1:0] win_q;
  logic [N-1:0]     pend;
  logic [N-1:0]     clr_all;
  logic             ack_take;
  logic             hit;
  logic [IDX_W-1:0] idx;
  logic [VEC_W-1:0] vec_n;

  assign ack_take = ack & irq_q;
  assign clr_all  = (clr_wr ? clr_mask : '0)
                  | (ack_take ? (N'(1) << win_q) : '0);

  intc_latch_bank #(.N(N)) u_latch (
    .clk(clk), .rst(rst), .set_i(src_req), .clr_i(clr_all), .pend_q(pend)
  );

  intc_prio_sel #(.N(N), .NG(NG), .VEC_W(VEC_W)) u_sel (
    .pend_i(pend), .ei_i(ei_q), .grp_i(grp_q),
    .hit_o(hit), .idx_o(idx), .vec_o(vec_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ei_q  <= 1'b0;
      grp_q <= '0;
      irq_q <= 1'b0;
      vec_q <= '0;
      win_q <= '0;
    end else begin
      if (ei_set)                 ei_q <= 1'b1;
      else if (ack_take | ei_clr) ei_q <= 1'b0;
      if (mask_wr) grp_q <= mask_data;
      irq_q <= hit & ~ack_take;
      vec_q <= vec_n;
      win_q <= idx;
    end
  end

  assign irq_o  = irq_q;
  assign vec_o  = vec_q;
  assign pend_o = pend;
  assign ei_o   = ei_q;

  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
    (ack && irq_o) |=> !irq_o); // R8
  AST_ACK_CLEARS_EI: assert property (@(posedge clk) disable iff (rst)
    (ack && irq_o && !ei_set) |=> !ei_o); // R8
  AST_IRQ_NEEDS_EI: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(ei_o)); // R5
  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (vec_o[0] == 1'b0 && vec_o >= VEC_W'(2) && vec_o <= VEC_W'(2 * N))); // R7
  AST_MASKED_NEEDS_GRP: assert property (@(posedge clk) disable iff (rst)
    (irq_o && vec_o != VEC_W'(2)) |-> $past(grp_q != '0)); // R6
endmodule

// File: tb/vintc_top_tb_top.sv
module vintc_top_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] src_req;
  logic       clr_wr;
  logic [5:0] clr_mask;
  logic       ei_set, ei_clr, mask_wr, ack;
  logic [3:0] mask_data;
  logic       irq_o, ei_o;
  logic [7:0] vec_o;
  logic [5:0] pend_o;
  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  vintc_top dut_i (
    .clk(clk), .rst(rst), .src_req(src_req), .clr_wr(clr_wr), .clr_mask(clr_mask),
    .ei_set(ei_set), .ei_clr(ei_clr), .mask_wr(mask_wr), .mask_data(mask_data),
    .ack(ack), .irq_o(irq_o), .vec_o(vec_o), .pend_o(pend_o), .ei_o(ei_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask
  task automatic pulse_src(input logic [5:0] m); src_req = m; step(); src_req = '0; endtask
  task automatic clear(input logic [5:0] m); clr_wr = 1; clr_mask = m; step(); clr_wr = 0; clr_mask = '0; endtask
  task automatic set_ei(); ei_set = 1; step(); ei_set = 0; endtask
  task automatic drop_ei(); ei_clr = 1; step(); ei_clr = 0; endtask
  task automatic wr_mask(input logic [3:0] m); mask_wr = 1; mask_data = m; step(); mask_wr = 0; endtask
  task automatic do_ack(); ack = 1; step(); ack = 0; endtask

  task automatic t_reset();
    rst = 1; step(); step(); rst = 0; step();
    chk("R1 pend", pend_o, 0); chk("R1 irq", irq_o, 0); chk("R1 ei", ei_o, 0);
    set_ei(); pulse_src(6'b000010); step();
    chk("R1 grp zero after reset", irq_o, 0);
    drop_ei(); clear(6'h3F);
  endtask

  task automatic t_latch_hold();
    pulse_src(6'b000100);
    chk("R2 set", pend_o, 6'b000100);
    step(); step(); step();
    chk("R2 held", pend_o, 6'b000100);
    chk("R2 no irq without ei", irq_o, 0);
    clear(6'h3F);
  endtask

  task automatic t_w1c();
    pulse_src(6'h3F);
    clear(6'b010101);
    chk("R3 partial clear", pend_o, 6'b101010);
    clear(6'b000000);
    chk("R3 zero mask no effect", pend_o, 6'b101010);
    clr_wr = 0; clr_mask = 6'h3F; step(); clr_mask = '0;
    chk("R3 mask without strobe", pend_o, 6'b101010);
    clear(6'h3F);
    chk("R3 all cleared", pend_o, 0);
  endtask

  task automatic t_set_wins();
    pulse_src(6'b000001);
    src_req = 6'b000010; clr_wr = 1; clr_mask = 6'b000011; step();
    src_req = '0; clr_wr = 0; clr_mask = '0;
    chk("R4 set beats clear", pend_o, 6'b000010);
    clear(6'h3F);
  endtask

  task automatic t_int0_ei();
    wr_mask(4'b0000);
    pulse_src(6'b000001); step();
    chk("R5 ei off blocks", irq_o, 0);
    set_ei();
    chk("R10 irq not yet", irq_o, 0);
    step();
    chk("R5 irq with ei only", irq_o, 1);
    chk("R5 vec", vec_o, 8'h02);
    drop_ei(); clear(6'h3F); step();
    chk("R10 irq gone", irq_o, 0);
    set_ei();
    pulse_src(6'b000001);
    chk("R10 latch now, irq later", irq_o, 0);
    step();
    chk("R10 irq one edge after latch", irq_o, 1);
    drop_ei(); clear(6'h3F); step();
  endtask

  task automatic t_mask_map();
    wr_mask(4'b0000); set_ei();
    pulse_src(6'b111110); step();
    chk("R6 all masked", irq_o, 0);
    wr_mask(4'b0010); step();
    chk("R6 bit1 irq", irq_o, 1); chk("R6 bit1 -> src3", vec_o, 8'h08);
    clear(6'b001000); step();
    chk("R6 bit1 shared -> src4", vec_o, 8'h0A);
    wr_mask(4'b0001); step();
    chk("R6 bit0 -> src5", vec_o, 8'h0C);
    wr_mask(4'b1000); step();
    chk("R6 bit3 -> src1", vec_o, 8'h04);
    wr_mask(4'b0100); step();
    chk("R6 bit2 -> src2", vec_o, 8'h06);
    drop_ei(); clear(6'h3F); step();
  endtask

  task automatic t_priority_ack();
    wr_mask(4'b1111);
    pulse_src(6'h3F);
    set_ei(); step();
    for (int k = 0; k < 6; k++) begin
      chk("R7 irq", irq_o, 1);
      chk("R7 vector order", vec_o, 2 + 2 * k);
      do_ack();
      chk("R8 irq dropped", irq_o, 0);
      chk("R8 ei cleared", ei_o, 0);
      chk("R8 winner cleared", pend_o, (6'h3F << (k + 1)) & 6'h3F);
      set_ei(); step();
    end
    chk("R7 none left", irq_o, 0);
    drop_ei();
  endtask

  task automatic t_ack_idle();
    wr_mask(4'b0000); set_ei();
    pulse_src(6'b000100); step();
    chk("R9 precondition irq", irq_o, 0);
    do_ack();
    chk("R9 pend unchanged", pend_o, 6'b000100);
    chk("R9 ei unchanged", ei_o, 1);
    drop_ei(); clear(6'h3F);
  endtask

  initial begin
    rst = 1; src_req = '0; clr_wr = 0; clr_mask = '0; ei_set = 0; ei_clr = 0;
    mask_wr = 0; mask_data = '0; ack = 0;
    t_reset();
    t_latch_hold();
    t_w1c();
    t_set_wins();
    t_int0_ei();
    t_mask_map();
    t_priority_ack();
    t_ack_idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule